// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Unit

This block is the interrupt front end for a bank of 32 general-purpose input lines. It sits on an APB-style register bus. Software chooses, for each line, whether the line is a level source or an edge source and which polarity counts as active. It also sets a per-line enable and a per-line mask. The unit drives one combined interrupt output and exposes two status views: raw, before masking, and masked.

Each input passes through a two-flop synchronizer and then an edge detector. An edge line that sees its chosen edge sets a pending latch. The latch stays set until software writes a 1 to that bit of the end-of-interrupt register, or until the line is disabled. A level line has no latch: its status bit follows the synchronized input. With a single line enabled and unmasked, the unit acts as a plain wire from that input to the interrupt output.

A three-state bus sequencer accepts register accesses:
- **BUS_IDLE** moves to **BUS_SETUP** when select is high and enable is low.
- **BUS_SETUP** moves to **BUS_ACCESS** when select and enable are both high. That is the only cycle in which a write commits.
- **BUS_SETUP** stays in **BUS_SETUP** when select is high and enable is low.
- **BUS_SETUP** returns to **BUS_IDLE** when select is low.
- **BUS_ACCESS** returns to **BUS_SETUP** on a new setup phase, and to **BUS_IDLE** otherwise.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every register reads 0: enable 0x30, mask 0x34, type 0x38, polarity 0x3C, masked status 0x40, raw status 0x44 and end-of-interrupt 0x4C. The interrupt output is low, and no line can raise it while its enable bit is 0.
- R2: A write to 0x30, 0x34, 0x38 or 0x3C stores the 32-bit value, and reading the same offset returns it. End-of-interrupt writes have no stored value, and 0x4C always reads 0.
- R3: A write commits only when the sequencer is in BUS_SETUP and sees select, enable and write all high. An access phase (select and enable high) that is not preceded by a setup phase is ignored and leaves the registers unchanged.
- R4: A line with type bit 1 is a level source. Its raw status bit equals the synchronized input when its polarity bit is 1 (active high), and the inverted input when its polarity bit is 0 (active low). The bit reflects an input change within two clock cycles.
- R5: A line with type bit 0 is an edge source. A rising input sets its pending bit when the polarity bit is 1, and a falling input sets it when the polarity bit is 0. The pending bit, shown in raw status, stays set after the input returns. Edges of the other direction, and changes of the polarity register itself, set nothing. A line set to level type holds no pending bit.
- R6: Writing 1 to bit N of 0x4C clears the pending bit of edge line N. Bits written as 0 leave pending bits alone, and such writes have no effect on level lines.
- R7: A mask bit of 1 hides its line: masked status equals raw status AND NOT mask, and raw status is unaffected by the mask. With all lines masked, the output stays low.
- R8: The interrupt output is high exactly when masked status is non-zero. A single enabled, unmasked level line therefore passes its input straight through to the output.
- R9: Clearing a line's enable bit clears its pending bit. A disabled line contributes 0 to raw status, and when it is re-enabled no pending event is left over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_enable | input | 1 | Register bus access-phase strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while selected |
| line_in | input | 32 | Asynchronous input lines |
| irq_out | output | 1 | Combined interrupt output |

## Verification
Faults inside this block surface at three places:
- A wrong pending latch appears in the raw status read-back, and in the interrupt output once the line is unmasked. A missed or spurious edge is visible within four cycles of the input change.
- A wrong sequencer state shows up on the next read of the register targeted by a malformed access, which then holds a value it should not.
- A broken synchronizer or polarity path makes a level line's status disagree with its input two cycles after the input settles.

The checks therefore read both status registers and sample the output after every input or configuration change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_SETUP  = 2'd1,
        BUS_ACCESS = 2'd2
    } bus_state_t;

    localparam logic [7:0] OFS_ENABLE = 8'h30;
    localparam logic [7:0] OFS_MASK   = 8'h34;
    localparam logic [7:0] OFS_TYPE   = 8'h38;
    localparam logic [7:0] OFS_POLAR  = 8'h3C;
    localparam logic [7:0] OFS_MSTAT  = 8'h40;
    localparam logic [7:0] OFS_RSTAT  = 8'h44;
    localparam logic [7:0] OFS_EOI    = 8'h4C;

endpackage

// File: rtl/gpio_irq_bus_fsm.sv
module gpio_irq_bus_fsm
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_enable,
    input  logic       bus_write,
    output logic       wr_commit,
    output bus_state_t state
);

    bus_state_t state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nxt;
    end

    // Next-state selection
    always_comb begin
        state_nxt = BUS_IDLE;
        unique case (state)
            BUS_IDLE: begin
                if (bus_sel && !bus_enable) state_nxt = BUS_SETUP;
                else                        state_nxt = BUS_IDLE;
            end
            BUS_SETUP: begin
                if (bus_sel && bus_enable)       state_nxt = BUS_ACCESS;
                else if (bus_sel && !bus_enable) state_nxt = BUS_SETUP;
                else                             state_nxt = BUS_IDLE;
            end
            BUS_ACCESS: begin
                if (bus_sel && !bus_enable) state_nxt = BUS_SETUP;
                else                        state_nxt = BUS_IDLE;
            end
            default: state_nxt = BUS_IDLE;
        endcase
    end

    // Outputs: a write lands only at the end of a proper setup phase
    always_comb begin
        wr_commit = 1'b0;
        unique case (state)
            BUS_SETUP:  wr_commit = bus_sel && bus_enable && bus_write;
            BUS_IDLE:   wr_commit = 1'b0;
            BUS_ACCESS: wr_commit = 1'b0;
            default:    wr_commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    input  logic [N-1:0]      raw_stat,
    input  logic [N-1:0]      masked_stat,
    output logic [N-1:0]      en_q,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      type_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      eoi_vec,
    output logic [N-1:0]      bus_rdata
);

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_TYP = ADDR_W'(OFS_TYPE);
    localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(OFS_POLAR);
    localparam logic [ADDR_W-1:0] A_MST = ADDR_W'(OFS_MSTAT);
    localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(OFS_RSTAT);
    localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(OFS_EOI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            type_q <= '0;
            pol_q  <= '0;
        end else if (wr_commit) begin
            if (bus_addr == A_EN)  en_q   <= bus_wdata;
            if (bus_addr == A_MSK) mask_q <= bus_wdata;
            if (bus_addr == A_TYP) type_q <= bus_wdata;
            if (bus_addr == A_POL) pol_q  <= bus_wdata;
        end
    end

    assign eoi_vec = (wr_commit && bus_addr == A_EOI) ? bus_wdata : '0;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (bus_addr == A_EN)  bus_rdata = en_q;
            if (bus_addr == A_MSK) bus_rdata = mask_q;
            if (bus_addr == A_TYP) bus_rdata = type_q;
            if (bus_addr == A_POL) bus_rdata = pol_q;
            if (bus_addr == A_MST) bus_rdata = masked_stat;
            if (bus_addr == A_RST) bus_rdata = raw_stat;
        end
    end

endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic en,
    input  logic lvl,
    input  logic pol,
    input  logic eoi,
    output logic edge_hit,
    output logic pend,
    output logic raw
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;
    logic                   rise;
    logic                   fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign cur      = sync_q[SYNC_STAGES-1];
    assign rise     = cur & ~prev_q;
    assign fall     = ~cur & prev_q;
    assign edge_hit = pol ? rise : fall;

    // A new edge wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pend <= 1'b0;
        else if (!en || lvl)     pend <= 1'b0;
        else if (edge_hit)       pend <= 1'b1;
        else if (eoi)            pend <= 1'b0;
    end

    assign raw = en & (lvl ? ~(cur ^ pol) : pend);

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int N           = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_enable,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      line_in,
    output logic              irq_out
);

    bus_state_t  bus_state;
    logic        wr_commit;
    logic [N-1:0] en_q, mask_q, type_q, pol_q, eoi_vec;
    logic [N-1:0] edge_vec, pend_vec, raw_vec, masked_vec;

    gpio_irq_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_enable(bus_enable),
        .bus_write (bus_write),
        .wr_commit (wr_commit),
        .state     (bus_state)
    );

    gpio_irq_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_commit  (wr_commit),
        .bus_sel    (bus_sel),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .raw_stat   (raw_vec),
        .masked_stat(masked_vec),
        .en_q       (en_q),
        .mask_q     (mask_q),
        .type_q     (type_q),
        .pol_q      (pol_q),
        .eoi_vec    (eoi_vec),
        .bus_rdata  (bus_rdata)
    );

    for (genvar i = 0; i < N; i++) begin : g_line
        gpio_irq_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (line_in[i]),
            .en      (en_q[i]),
            .lvl     (type_q[i]),
            .pol     (pol_q[i]),
            .eoi     (eoi_vec[i]),
            .edge_hit(edge_vec[i]),
            .pend    (pend_vec[i]),
            .raw     (raw_vec[i])
        );
    end

    assign masked_vec = raw_vec & ~mask_q;
    assign irq_out    = |masked_vec;

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
    import gpio_irq_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_enable,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic              irq_out,
    input bus_state_t        bus_state,
    input logic [N-1:0]      en_q,
    input logic [N-1:0]      mask_q,
    input logic [N-1:0]      type_q,
    input logic [N-1:0]      pend_vec,
    input logic [N-1:0]      edge_vec,
    input logic [N-1:0]      eoi_vec
);

    assert_quiet_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (en_q != '0));

    assert_access_follows_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == BUS_ACCESS) |-> ($past(bus_state) == BUS_SETUP));

    assert_mask_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == BUS_SETUP && bus_sel && bus_enable && bus_write
         && bus_addr == ADDR_W'(OFS_MASK)) |=> (mask_q == $past(bus_wdata)));

    assert_level_holds_no_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec & type_q & $past(type_q)) == '0);

    assert_eoi_clears_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_vec != '0) |=> ((pend_vec & $past(eoi_vec) & ~$past(edge_vec)) == '0));

    assert_all_masked_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_out);

    assert_disable_drops_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec & ~$past(en_q)) == '0);

endmodule

bind gpio_irq_unit gpio_irq_checker #(.N(N), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_enable(bus_enable),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .bus_state (bus_state),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .type_q    (type_q),
    .pend_vec  (pend_vec),
    .edge_vec  (edge_vec),
    .eoi_vec   (eoi_vec)
);

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] line_in = '0;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        logic [7:0]  addr;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    logic [31:0] m_en = '0, m_mask = '0, m_type = '0, m_pol = '0, m_pend = '0, m_line = '0;

    gpio_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .line_in(line_in), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] exp_raw();
        return m_en & ((m_type & ~(m_line ^ m_pol)) | (~m_type & m_pend));
    endfunction

    function automatic logic [31:0] exp_masked();
        return exp_raw() & ~m_mask;
    endfunction

    // Monitor: compares each read access against the scoreboard head
    always begin
        @(posedge clk);
        #1;
        if (bus_sel && bus_enable && !bus_write) begin
            if (sb_q.size() == 0) begin
                errors++; checks++;
                $display("FAIL %s: unexpected read at %h actual %h expected none", "R2", bus_addr, bus_rdata);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: addr %h actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_enable = 0; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_enable = 1;
        @(negedge clk);
        bus_sel = 0; bus_enable = 0; bus_write = 0;
        case (a)
            8'h30: begin m_en = d; m_pend &= d; end
            8'h34: m_mask = d;
            8'h38: begin m_type = d; m_pend &= ~d; end
            8'h3C: m_pol = d;
            8'h4C: m_pend &= ~d;
            default: ;
        endcase
        repeat (2) @(negedge clk);
    endtask

    task automatic check_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.exp = e; it.addr = a; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_sel = 1; bus_enable = 0; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_enable = 1;
        @(negedge clk);
        bus_sel = 0; bus_enable = 0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (irq_out !== e) begin
            errors++;
            $display("FAIL %s: irq_out actual %b expected %b", tag, irq_out, e);
        end
    endtask

    task automatic set_lines(input logic [31:0] nv);
        logic [31:0] ev;
        ev = (m_pol & nv & ~m_line) | (~m_pol & ~nv & m_line);
        m_pend |= ev & m_en & ~m_type;
        m_line = nv;
        @(negedge clk);
        line_in = nv;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_status(input string tag);
        check_rd(8'h44, exp_raw(), tag);
        check_rd(8'h40, exp_masked(), tag);
        check_irq(exp_masked() != 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1: reset state
        check_irq(1'b0, "R1");
        check_rd(8'h30, 32'h0, "R1");
        check_rd(8'h34, 32'h0, "R1");
        check_rd(8'h38, 32'h0, "R1");
        check_rd(8'h3C, 32'h0, "R1");
        check_rd(8'h40, 32'h0, "R1");
        check_rd(8'h44, 32'h0, "R1");
        check_rd(8'h4C, 32'h0, "R1");

        // R2: configuration write and read-back
        bus_wr(8'h38, 32'hFFFF_0000);
        bus_wr(8'h3C, 32'h00FF_00FF);
        check_rd(8'h38, 32'hFFFF_0000, "R2");
        check_rd(8'h3C, 32'h00FF_00FF, "R2");
        bus_wr(8'h4C, 32'hFFFF_FFFF);
        check_rd(8'h4C, 32'h0, "R2");

        // R3: access phase without setup is ignored
        @(negedge clk);
        bus_sel = 1; bus_enable = 1; bus_write = 1; bus_addr = 8'h34; bus_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        bus_sel = 0; bus_enable = 0; bus_write = 0;
        check_rd(8'h34, 32'h0, "R3");
        bus_wr(8'h34, 32'h0000_F000);
        check_rd(8'h34, 32'h0000_F000, "R3");
        bus_wr(8'h34, 32'h0);

        // R4: level lines follow the input with polarity
        bus_wr(8'h30, 32'hFFFF_FFFF);
        check_rd(8'h30, 32'hFFFF_FFFF, "R2");
        check_status("R4");
        set_lines(32'h00FF_00FF);
        check_status("R4");

        // R5: edge lines latch the chosen edge only
        set_lines(32'h0000_0000);
        check_status("R5");
        set_lines(32'h0000_FF00);
        check_status("R5");
        set_lines(32'h0000_0000);
        check_status("R5");
        bus_wr(8'h3C, 32'h00FF_FF00);
        check_status("R5");
        bus_wr(8'h3C, 32'h00FF_00FF);

        // R6: end-of-interrupt clears selected edge pendings only
        bus_wr(8'h4C, 32'h0F0F_0F0F);
        check_status("R6");

        // R7: masking
        bus_wr(8'h34, ~(32'h1 << 12));
        check_status("R7");
        bus_wr(8'h34, ~(32'h1 << 1));
        check_status("R7");
        bus_wr(8'h34, 32'hFFFF_FFFF);
        check_status("R7");
        bus_wr(8'h34, 32'h0);

        // R9: disabling drops pending state
        bus_wr(8'h30, 32'hFFFF_EFFF);
        check_status("R9");
        bus_wr(8'h30, 32'hFFFF_FFFF);
        check_status("R9");

        // R8: single-line pass-through
        bus_wr(8'h30, 32'h1 << 12);
        bus_wr(8'h34, ~(32'h1 << 12));
        bus_wr(8'h38, 32'hFFFF_1000);
        bus_wr(8'h3C, 32'h00FF_10FF);
        set_lines(32'h1 << 12);
        check_irq(1'b1, "R8");
        check_status("R8");
        set_lines(32'h0);
        check_irq(1'b0, "R8");
        check_status("R8");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++; checks++;
            $display("FAIL R2: pending reads actual %0d expected 0", sb_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule